// File: doc/BRIEF.md
# Keyed Random-Subset XOR Encryptor

This block turns one message bit per clock into one ciphertext bit, and it can also reverse the step. Each clock a fresh random word comes in. A bank of selector lanes each picks one bit of that word. Every lane's pick is set by a small select code. Together these codes form the secret key, which is shifted in one bit at a time. The picked bits are folded together with XOR and combined with the message bit. The result goes to a single registered output.

Decryption needs the same random word and the same key. The block evaluates the keyed function for both possible plaintext values and reports the value whose result matches the received ciphertext bit. Both ends hold the key. The random word reaches both ends by some other path, so the block only combines what it receives.

Top module: `keyed_xor_encryptor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every key select code to 0, and drives `key_ready`, `out_valid` and `out_bit` to 0.
- R2: `key_ready` rises at the clock edge that accepts the 320th key bit since reset, counting edges where `key_load_en` is high. It is still low after 319 such bits. Once high, it stays high until reset, even while more bits are shifted in.
- R3: In encrypt mode (`decrypt` = 0), the result is `data_bit` XOR the XOR of the 64 selected bits.
- R4: Key bits enter MSB first. The most recent 320 key bits, split into consecutive groups of five, form the 64 select codes. Further loading shifts the oldest group out and the newest group in.
- R5: In decrypt mode (`decrypt` = 1), the block treats `data_bit` as ciphertext. It outputs the plaintext value p for which p XOR (the same reduction) equals `data_bit`. So a ciphertext from R3, given back with the same word and key, returns the original message bit.
- R6: `out_valid` is high exactly one cycle after an edge where `in_valid` and `key_ready` were both high. An input accepted while `key_ready` is low produces no output.
- R7: In every cycle where `out_valid` is low, `out_bit` keeps its previous value.
- R8: Back-to-back inputs give back-to-back results: one result per clock with a fixed one-cycle latency.
- R9: A select code of value v picks bit v of `rnd_word`, where bit 0 is the least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_load_en | input | 1 | Shift `key_bit` into the key chain this cycle |
| key_bit | input | 1 | Serial key data, MSB of each code first |
| key_ready | output | 1 | A full key has been loaded |
| in_valid | input | 1 | `rnd_word`, `data_bit` and `decrypt` are valid |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| rnd_word | input | 32 | Fresh random word for this cycle |
| data_bit | input | 1 | Message bit (encrypt) or ciphertext bit (decrypt) |
| out_valid | output | 1 | `out_bit` carries a new result |
| out_bit | output | 1 | Ciphertext or recovered message bit |

## Verification
A wrong select code or a misaligned key field flips the reduction only for words where the two candidate bits differ. With random words, about half of the cycles after such a fault show a wrong `out_bit` at the next edge. A wrong key-bit count shows up as `key_ready` rising one edge early or late. A fault in the valid path shows at once, as a missing or extra `out_valid` one cycle after the input. Key field alignment is checked with single-lane codes whose bit-reversed value would pick a different word bit.

// File: rtl/kxe_pkg.sv
package kxe_pkg;
   typedef enum logic {
      KXE_ENCRYPT = 1'b0,
      KXE_DECRYPT = 1'b1
   } kxe_mode_e;

   localparam int unsigned KXE_RND_W_DEF = 32;
   localparam int unsigned KXE_LANES_DEF = 64;
endpackage

// File: rtl/kxe_key_chain.sv
// Serial-in key chain: LANES select codes of SEL_W bits, plus a ready flag.
module kxe_key_chain #(
   parameter int unsigned LANES = 64,
   parameter int unsigned SEL_W = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     shift_en,
   input  logic                     bit_in,
   output logic [LANES*SEL_W-1:0]   sel_flat,
   output logic                     ready
);
   localparam int unsigned KEY_BITS = LANES * SEL_W;
   localparam int unsigned CW       = $clog2(KEY_BITS + 1);

   if (KEY_BITS < 2) begin : g_bad_size
      $error("kxe_key_chain: key must hold at least two bits");
   end

   logic [KEY_BITS-1:0] chain_q;
   logic [CW-1:0]       cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         cnt_q   <= '0;
      end else if (shift_en) begin
         chain_q <= {chain_q[KEY_BITS-2:0], bit_in};
         if (cnt_q != CW'(KEY_BITS))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready    = (cnt_q == CW'(KEY_BITS));
   assign sel_flat = chain_q;
endmodule

// File: rtl/kxe_lane_mux.sv
// One RND_W-to-1 selector per lane.
module kxe_lane_mux #(
   parameter int unsigned RND_W = 32,
   parameter int unsigned LANES = 64,
   parameter int unsigned SEL_W = 5
) (
   input  logic [RND_W-1:0]         rnd,
   input  logic [LANES*SEL_W-1:0]   sel_flat,
   output logic [LANES-1:0]         picked
);
   if (RND_W != (1 << SEL_W)) begin : g_bad_width
      $error("kxe_lane_mux: RND_W must equal 2**SEL_W");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SEL_W-1:0] sel;
      assign sel       = sel_flat[i*SEL_W +: SEL_W];
      assign picked[i] = rnd[sel];
   end
endmodule

// File: rtl/kxe_xor_tree.sv
// N-input XOR reduction: balanced heap-ordered tree or flat operator.
module kxe_xor_tree #(
   parameter int unsigned N        = 64,
   parameter bit          BALANCED = 1'b1
) (
   input  logic [N-1:0] din,
   output logic         dout
);
   localparam int unsigned LEVELS = (N > 1) ? $clog2(N) : 0;
   localparam int unsigned P      = 1 << LEVELS;

   if (BALANCED) begin : g_tree
      logic node [2*P-1];
      for (genvar i = 0; i < P; i++) begin : g_leaf
         if (i < N) begin : g_used
            assign node[P-1+i] = din[i];
         end else begin : g_pad
            assign node[P-1+i] = 1'b0;
         end
      end
      for (genvar j = 0; j < P - 1; j++) begin : g_node
         assign node[j] = node[2*j+1] ^ node[2*j+2];
      end
      assign dout = node[0];
   end else begin : g_flat
      assign dout = ^din;
   end
endmodule

// File: rtl/keyed_xor_encryptor.sv
module keyed_xor_encryptor
   import kxe_pkg::*;
#(
   parameter int unsigned RND_W       = KXE_RND_W_DEF,
   parameter int unsigned LANES       = KXE_LANES_DEF,
   parameter bit          TREE_BALANCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             key_load_en,
   input  logic             key_bit,
   output logic             key_ready,
   input  logic             in_valid,
   input  logic             decrypt,
   input  logic [RND_W-1:0] rnd_word,
   input  logic             data_bit,
   output logic             out_valid,
   output logic             out_bit
);
   localparam int unsigned SEL_W = $clog2(RND_W);

   if (LANES < 1) begin : g_bad_lanes
      $error("keyed_xor_encryptor: LANES must be at least 1");
   end

   logic [LANES*SEL_W-1:0] sel_flat;
   logic [LANES-1:0]       picked;
   logic                   reduced;
   logic                   result;
   kxe_mode_e              mode;

   kxe_key_chain #(.LANES(LANES), .SEL_W(SEL_W)) i_key (
      .clk     (clk),
      .rst     (rst),
      .shift_en(key_load_en),
      .bit_in  (key_bit),
      .sel_flat(sel_flat),
      .ready   (key_ready)
   );

   kxe_lane_mux #(.RND_W(RND_W), .LANES(LANES), .SEL_W(SEL_W)) i_mux (
      .rnd     (rnd_word),
      .sel_flat(sel_flat),
      .picked  (picked)
   );

   kxe_xor_tree #(.N(LANES), .BALANCED(TREE_BALANCE)) i_tree (
      .din (picked),
      .dout(reduced)
   );

   assign mode = kxe_mode_e'(decrypt);

   // Decrypt: f(p) = p ^ reduced; the answer is the p whose f(p) matches.
   always_comb begin
      if (mode == KXE_DECRYPT)
         result = ((1'b1 ^ reduced) == data_bit);
      else
         result = data_bit ^ reduced;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_bit   <= 1'b0;
      end else begin
         out_valid <= in_valid && key_ready;
         if (in_valid && key_ready)
            out_bit <= result;
      end
   end
endmodule

// File: rtl/kxe_checker.sv
module kxe_checker (
   input logic clk,
   input logic rst,
   input logic key_load_en,
   input logic key_ready,
   input logic in_valid,
   input logic out_valid,
   input logic out_bit
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !key_ready && !out_bit));

   // R2
   ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      key_ready |=> key_ready);

   // R2
   ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(key_ready) |-> $past(key_load_en));

   // R6
   valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid && key_ready));

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && key_ready) |=> out_valid);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(out_bit));
endmodule

bind keyed_xor_encryptor kxe_checker i_chk (
   .clk        (clk),
   .rst        (rst),
   .key_load_en(key_load_en),
   .key_ready  (key_ready),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .out_bit    (out_bit)
);

// File: tb/test_keyed_xor_encryptor.sv
`timescale 1ns/1ps
module test_keyed_xor_encryptor;
   localparam int LANES = 64;
   localparam int SEL_W = 5;
   localparam int NTAB  = 8;

   // {select code of the last-loaded group, rnd word, data bit, decrypt, expected}
   // All other groups are 0, so the reduction is rnd[0] ^ rnd[v] (R9).
   localparam logic [39:0] TAB [NTAB] = '{
      {5'd0,  32'h0000_0001, 1'b1, 1'b0, 1'b1},
      {5'd5,  32'h0000_0020, 1'b0, 1'b0, 1'b1},
      {5'd5,  32'h0000_0021, 1'b0, 1'b0, 1'b0},
      {5'd31, 32'h8000_0000, 1'b1, 1'b0, 1'b0},
      {5'd31, 32'h0000_0001, 1'b1, 1'b1, 1'b0},
      {5'd16, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
      {5'd16, 32'h0001_0000, 1'b0, 1'b0, 1'b1},
      {5'd3,  32'h0000_0009, 1'b1, 1'b0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        key_load_en, key_bit, in_valid, decrypt, data_bit;
   logic [31:0] rnd_word;
   logic        key_ready, out_valid, out_bit;

   int checks = 0;
   int errors = 0;
   logic [4:0]  bkey [LANES];
   logic [31:0] lfsr = 32'hACE1_2468;

   always #2.5 clk = ~clk;

   keyed_xor_encryptor i_keyed_xor_encryptor (
      .clk(clk), .rst(rst), .key_load_en(key_load_en), .key_bit(key_bit),
      .key_ready(key_ready), .in_valid(in_valid), .decrypt(decrypt),
      .rnd_word(rnd_word), .data_bit(data_bit),
      .out_valid(out_valid), .out_bit(out_bit)
   );

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   // stream order: group 63 first, MSB first; group 0 last
   task automatic load_key();
      for (int g = LANES - 1; g >= 0; g--) begin
         for (int b = SEL_W - 1; b >= 0; b--) begin
            key_load_en = 1'b1;
            key_bit     = bkey[g][b];
            step();
         end
      end
      key_load_en = 1'b0;
   endtask

   function automatic logic ref_reduce(input logic [31:0] w);
      logic r = 1'b0;
      for (int g = 0; g < LANES; g++) r ^= w[bkey[g]];
      return r;
   endfunction

   task automatic do_reset();
      rst = 1'b1; key_load_en = 0; key_bit = 0; in_valid = 0;
      decrypt = 0; data_bit = 0; rnd_word = '0;
      step(); step();
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic c, m, rb;
      do_reset();
      @(negedge clk);
      // R1 reset state
      check("R1 key_ready", key_ready, 1'b0);
      check("R1 out_valid", out_valid, 1'b0);
      check("R1 out_bit",   out_bit,   1'b0);

      // R6 input while key not ready gives nothing
      in_valid = 1; rnd_word = 32'hFFFF_FFFF; data_bit = 1;
      step();
      in_valid = 0;
      check("R6 no output before key", out_valid, 1'b0);

      // R2 exact count: 319 bits not ready, 320th makes ready
      for (int i = 0; i < 319; i++) begin
         key_load_en = 1; key_bit = 0; step();
      end
      check("R2 after 319", key_ready, 1'b0);
      key_load_en = 1; step(); key_load_en = 0;
      check("R2 after 320", key_ready, 1'b1);

      // table of directed vectors (R3 R5 R9 R4 alignment)
      for (int t = 0; t < NTAB; t++) begin
         for (int g = 0; g < LANES; g++) bkey[g] = '0;
         bkey[0] = TAB[t][39:35];
         load_key();
         in_valid = 1; rnd_word = TAB[t][34:3];
         data_bit = TAB[t][2]; decrypt = TAB[t][1];
         step();
         in_valid = 0;
         check("R6 table out_valid", out_valid, 1'b1);
         check(TAB[t][1] ? "R5 table decrypt" : "R3 R9 table encrypt",
               out_bit, TAB[t][0]);
      end

      // R4 continued loading: five more bits (9) push the oldest group out.
      // Groups now: 62 zeros, 3, 9 -> reduction rnd[3]^rnd[9].
      for (int b = 4; b >= 0; b--) begin
         key_load_en = 1; key_bit = 1'(5'd9 >> b); step();
      end
      key_load_en = 0;
      check("R2 ready stays during reload", key_ready, 1'b1);
      in_valid = 1; decrypt = 0; data_bit = 0; rnd_word = 32'h0000_0200;
      step();
      check("R4 shifted key", out_bit, 1'b1);
      rnd_word = 32'h0000_0208;
      step();
      in_valid = 0;
      check("R8 back-to-back valid", out_valid, 1'b1);
      check("R4 shifted key both picks", out_bit, 1'b0);

      // R7 hold while idle
      rnd_word = 32'hFFFF_FFFF; data_bit = 1;
      step();
      check("R7 out_valid idle", out_valid, 1'b0);
      check("R7 out_bit held", out_bit, 1'b0);

      // R1 reset after a loaded key
      do_reset();
      @(negedge clk);
      check("R1 key cleared", key_ready, 1'b0);

      // random key, then 5000 encrypt/decrypt pairs (10000 cycles)
      for (int g = 0; g < LANES; g++) begin
         lfsr = lfsr_next(lfsr);
         bkey[g] = lfsr[4:0];
      end
      load_key();
      for (int k = 0; k < 5000; k++) begin
         lfsr = lfsr_next(lfsr);
         m  = lfsr[7];
         rb = ref_reduce(lfsr);
         in_valid = 1; decrypt = 0; data_bit = m; rnd_word = lfsr;
         step();
         c = out_bit;
         check("R3 random encrypt", c, m ^ rb);
         decrypt = 1; data_bit = c;
         step();
         check("R8 decrypt valid", out_valid, 1'b1);
         check("R5 random decrypt", out_bit, m);
      end
      in_valid = 0;
      step();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule